// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, weekday, day of month, month and a two-digit year, all in packed BCD, and moves them forward by one second whenever a single-cycle `sec_tick` enable arrives. The hours field runs in either 24-hour or 12-hour form with a PM flag, under a mode bit in the first control register. The month register carries a century flag that marks years 2000 and later. A second control register holds two sticky status flags: one reports that the oscillator stopped, the other reports low supply voltage.

A host reaches the registers through a simple register port. `host_sel` frames an access session, and inside it single-cycle write and read strobes address one register at a time. Read data appears on `host_rdata` one cycle after the read strobe and holds until the next read. While a session is open the time registers are frozen, so a multi-register read or write always sees or sets one consistent instant. A tick that lands inside a session is remembered and applied once, as soon as the session closes.

Top module: `bcd_rtc_bank`

## Requirements
- R1: A read strobe (`host_re` with `host_sel` high) loads `host_rdata` at the next clock edge, and `host_rdata` holds its value otherwise. Addresses 7 to 13 read as 0x00. The seconds register reads with bit 7 at 0.
- R2: A write strobe stores only the field bits: seconds and minutes keep bits 6:0, hours and day keep bits 5:0, weekday keeps bits 2:0, month keeps bits 7 and 4:0, and year, control-1 and control-2 keep all 8 bits. Writes to addresses 7 to 13 have no effect.
- R3: After reset the registers read as follows: seconds 0x00, minutes 0x00, hours 0x12 (12-hour midnight), weekday 0x00, day 0x01, month 0x01, year 0x00, control-1 0x00 and control-2 0x10. Control-2 bit 4 is the oscillator-stop flag.
- R4: Seconds count 0x00..0x59 in BCD. Passing 0x59 wraps to 0x00 and advances minutes, which wrap the same way.
- R5: With control-1 bit 5 set (24-hour mode), hours count 0x00..0x23, and 0x23 wraps to 0x00 and advances the day.
- R6: With control-1 bit 5 clear, hours bit 5 is PM and bits 4:0 count 0x12, 0x01..0x11. AM 11 (0x11) goes to PM 12 (0x32), 12 goes to 1 with PM unchanged, and PM 11 (0x31) goes to AM 12 (0x12) and advances the day.
- R7: The weekday counts 0..6 and wraps 6 to 0 on each day advance.
- R8: The day wraps to 0x01 and advances the month after the month's last day: day 30 for months 04, 06, 09 and 11, day 31 for the other months, and for month 02 day 29 when the binary value of the BCD year is a multiple of 4 and day 28 otherwise.
- R9: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00 and toggles month bit 7 (the century flag).
- R10: Ticks that arrive while `host_sel` is high are held and produce exactly one advance, in the first cycle after `host_sel` falls, however many ticks arrived during the session.
- R11: Control-2 bit 6 is set while `vlow_in` is high. Writing 0 to bit 4 or bit 6 clears that flag, and writing 1 leaves it unchanged. The other control-2 bits store as written. Control-1 bit 5 selects 24-hour mode.
- R12: No time register advances while `host_sel` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle enable, once per second |
| vlow_in | input | 1 | Low-supply detector level |
| host_sel | input | 1 | Host session active; freezes the time registers |
| host_we | input | 1 | Write strobe (qualified by host_sel) |
| host_re | input | 1 | Read strobe (qualified by host_sel) |
| host_addr | input | ADDR_W (4) | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after a read strobe |

## Verification
The bench drives the cascade of carries at each level: a second carry without a minute carry, a full wrap from 23:59:59 on 31 December 99 into the century, 12-hour noon and midnight crossings, and every month length, including a leap February in year 00. A design that got these wrong would show a BCD digit such as 0x5A or 0x60, or skip or repeat a day at month end, or put noon or midnight in the wrong half of the day. Ticks sent during an open session check that the time stays frozen and then moves exactly one second; a faulty design would either tear a multi-register read or lose or double seconds. Control-2 writes with ones and zeros in the flag positions show whether a write can set a flag that only hardware should set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned BYTE_W = 8;

  // Register addresses; the host decodes these, so they are fixed
  localparam int unsigned ADR_SEC  = 0;
  localparam int unsigned ADR_MIN  = 1;
  localparam int unsigned ADR_HOUR = 2;
  localparam int unsigned ADR_WDAY = 3;
  localparam int unsigned ADR_DAY  = 4;
  localparam int unsigned ADR_MON  = 5;
  localparam int unsigned ADR_YEAR = 6;
  localparam int unsigned ADR_CTL1 = 14;
  localparam int unsigned ADR_CTL2 = 15;

  localparam logic [7:0] MODE24_BIT  = 8'h20;
  localparam logic [7:0] FLAG_MASK   = 8'h50;
  localparam logic [7:0] OSC_STOP    = 8'h10;
  localparam logic [7:0] VOLT_LOW    = 8'h40;

  // Add one to a two-digit packed BCD value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Leap test on a BCD year: binary value divisible by 4
  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  // Last day (BCD) of a month; bit 7 of the month byte is ignored
  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m[4:0])
      5'h02: return bcd_leap(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  // Next 12-hour value: bit 5 is PM, bits 4:0 run 12,1..11
  function automatic logic [7:0] hour12_next(input logic [7:0] h);
    case (h[4:0])
      5'h11: return {2'b00, ~h[5], 5'h12};
      5'h12: return {2'b00, h[5], 5'h01};
      default: return (bcd_inc(h & 8'h1F)) | (h & 8'h20);
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_hold.sv
module rtc_tick_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  output logic adv,
  output logic pend
);
  logic pend_q;

  assign adv  = !busy && (tick || pend_q);
  assign pend = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (busy) pend_q <= pend_q | tick;
    else           pend_q <= pend_q & tick;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              mode24,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] sec_q,
  output logic [BYTE_W-1:0] min_q,
  output logic [BYTE_W-1:0] hour_q,
  output logic [BYTE_W-1:0] wday_q,
  output logic [BYTE_W-1:0] day_q,
  output logic [BYTE_W-1:0] mon_q,
  output logic [BYTE_W-1:0] year_q,
  output logic              sec_wrap,
  output logic              min_wrap,
  output logic              hour_wrap,
  output logic              day_wrap,
  output logic              mon_wrap,
  output logic              year_wrap
);
  logic [BYTE_W-1:0] hour_top, hour_nx, mon_nx;

  assign hour_top  = mode24 ? 8'h23 : 8'h31;
  assign sec_wrap  = adv && (sec_q == 8'h59);
  assign min_wrap  = sec_wrap && (min_q == 8'h59);
  assign hour_wrap = min_wrap && (hour_q == hour_top);
  assign day_wrap  = hour_wrap && (day_q == month_last(mon_q, year_q));
  assign mon_wrap  = day_wrap && (mon_q[4:0] == 5'h12);
  assign year_wrap = mon_wrap && (year_q == 8'h99);

  always_comb begin
    if (mode24) hour_nx = hour_wrap ? 8'h00 : bcd_inc(hour_q);
    else        hour_nx = hour12_next(hour_q);
    if (mon_wrap) mon_nx = {mon_q[7] ^ year_wrap, 7'h01};
    else          mon_nx = bcd_inc(mon_q & 8'h1F) | (mon_q & 8'h80);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h12;
      wday_q <= 8'h00;
      day_q  <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(ADR_SEC):  sec_q  <= wr_data & 8'h7F;
        ADDR_W'(ADR_MIN):  min_q  <= wr_data & 8'h7F;
        ADDR_W'(ADR_HOUR): hour_q <= wr_data & 8'h3F;
        ADDR_W'(ADR_WDAY): wday_q <= wr_data & 8'h07;
        ADDR_W'(ADR_DAY):  day_q  <= wr_data & 8'h3F;
        ADDR_W'(ADR_MON):  mon_q  <= wr_data & 8'h9F;
        ADDR_W'(ADR_YEAR): year_q <= wr_data;
        default: ;
      endcase
    end else if (adv) begin
      sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (sec_wrap)  min_q  <= min_wrap ? 8'h00 : bcd_inc(min_q);
      if (min_wrap)  hour_q <= hour_nx;
      if (hour_wrap) begin
        wday_q <= (wday_q >= 8'h06) ? 8'h00 : wday_q + 8'h01;
        day_q  <= day_wrap ? 8'h01 : bcd_inc(day_q);
      end
      if (day_wrap)  mon_q  <= mon_nx;
      if (mon_wrap)  year_q <= year_wrap ? 8'h00 : bcd_inc(year_q);
    end
  end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              vlow,
  output logic [BYTE_W-1:0] ctl1_q,
  output logic [BYTE_W-1:0] ctl2_q
);
  logic [BYTE_W-1:0] ctl2_wr, ctl2_nx;

  // Plain bits take the written value; flag bits may only be cleared
  assign ctl2_wr = (wr_data & ~FLAG_MASK) | (ctl2_q & wr_data & FLAG_MASK);
  assign ctl2_nx = ((wr_en && wr_addr == ADDR_W'(ADR_CTL2)) ? ctl2_wr : ctl2_q)
                   | (vlow ? VOLT_LOW : 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl1_q <= 8'h00;
      ctl2_q <= OSC_STOP;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(ADR_CTL1)) ctl1_q <= wr_data;
      ctl2_q <= ctl2_nx;
    end
  end
endmodule

// File: rtl/bcd_rtc_bank.sv
module bcd_rtc_bank
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              vlow_in,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata
);
  logic wr_en, rd_en, adv, pend, mode24;
  logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap, year_wrap;
  logic [BYTE_W-1:0] sec_q, min_q, hour_q, wday_q, day_q, mon_q, year_q;
  logic [BYTE_W-1:0] ctl1_q, ctl2_q, rd_mux;

  assign wr_en  = host_sel && host_we;
  assign rd_en  = host_sel && host_re;
  assign mode24 = |(ctl1_q & MODE24_BIT);

  rtc_tick_hold u_hold (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .busy(host_sel),
    .adv(adv), .pend(pend)
  );

  rtc_time_chain #(.ADDR_W(ADDR_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .adv(adv), .mode24(mode24),
    .wr_en(wr_en), .wr_addr(host_addr), .wr_data(host_wdata),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .wday_q(wday_q),
    .day_q(day_q), .mon_q(mon_q), .year_q(year_q),
    .sec_wrap(sec_wrap), .min_wrap(min_wrap), .hour_wrap(hour_wrap),
    .day_wrap(day_wrap), .mon_wrap(mon_wrap), .year_wrap(year_wrap)
  );

  rtc_ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(host_addr),
    .wr_data(host_wdata), .vlow(vlow_in), .ctl1_q(ctl1_q), .ctl2_q(ctl2_q)
  );

  always_comb begin
    case (host_addr)
      ADDR_W'(ADR_SEC):  rd_mux = sec_q;
      ADDR_W'(ADR_MIN):  rd_mux = min_q;
      ADDR_W'(ADR_HOUR): rd_mux = hour_q;
      ADDR_W'(ADR_WDAY): rd_mux = wday_q;
      ADDR_W'(ADR_DAY):  rd_mux = day_q;
      ADDR_W'(ADR_MON):  rd_mux = mon_q;
      ADDR_W'(ADR_YEAR): rd_mux = year_q;
      ADDR_W'(ADR_CTL1): rd_mux = ctl1_q;
      ADDR_W'(ADR_CTL2): rd_mux = ctl2_q;
      default:           rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     host_rdata <= 8'h00;
    else if (rd_en) host_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_bank_chk.sv
module rtc_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_sel,
  input logic       host_re,
  input logic       sec_tick,
  input logic       vlow_in,
  input logic       adv,
  input logic       pend,
  input logic       mode24,
  input logic       sec_wrap,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] day_q,
  input logic [7:0] ctl2_q,
  input logic [7:0] host_rdata
);
  // R12
  frozen_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !host_sel);

  // R10
  tick_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && sec_tick) |=> pend);

  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> (sec_q == 8'h00));

  // R5
  h24_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode24 && hour_q == 8'h23 && min_q == 8'h59 && sec_q == 8'h59)
    |=> (hour_q == 8'h00 && !$stable(day_q)));

  // R6
  h12_noon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !mode24 && hour_q == 8'h11 && min_q == 8'h59 && sec_q == 8'h59)
    |=> (hour_q == 8'h32));

  // R11
  osc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ctl2_q[4]));

  // R11
  vlow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlow_in |=> ctl2_q[6]);

  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_sel && host_re) |=> $stable(host_rdata));
endmodule

bind bcd_rtc_bank rtc_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_re(host_re),
  .sec_tick(sec_tick), .vlow_in(vlow_in), .adv(adv), .pend(pend),
  .mode24(mode24), .sec_wrap(sec_wrap), .sec_q(sec_q), .min_q(min_q),
  .hour_q(hour_q), .day_q(day_q), .ctl2_q(ctl2_q), .host_rdata(host_rdata)
);

// File: tb/tb_bcd_rtc_bank.sv
`timescale 1ns/1ps
module tb_bcd_rtc_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       vlow_in = 1'b0;
  logic       host_sel = 1'b0;
  logic       host_we = 1'b0;
  logic       host_re = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  bcd_rtc_bank dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .vlow_in(vlow_in),
    .host_sel(host_sel), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  // Monitor: a read strobe seen at an edge yields data by the next falling edge
  always @(posedge clk) begin
    if (rst_n && host_sel && host_re) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read result act=%h exp=none", host_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (host_rdata !== e) begin
          fails++;
          $display("FAIL %s act=%h exp=%h", t, host_rdata, e);
        end
      end
    end
  end

  task automatic sel_on();
    @(negedge clk) host_sel = 1'b1;
  endtask

  task automatic sel_off();
    @(negedge clk) host_sel = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] c1, input logic [7:0] h,
                          input logic [7:0] m, input logic [7:0] s,
                          input logic [7:0] w, input logic [7:0] d,
                          input logic [7:0] mo, input logic [7:0] y);
    sel_on();
    wr(4'd14, c1); wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
    wr(4'd3, w); wr(4'd4, d); wr(4'd5, mo); wr(4'd6, y);
    sel_off();
  endtask

  // Day-end probe: set 23:59:59 in 24-hour mode, tick, read day and month
  task automatic month_end(input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y, input logic [7:0] ed,
                           input logic [7:0] emo, input string t);
    set_time(8'h20, 8'h23, 8'h59, 8'h59, 8'h00, d, mo, y);
    pulse_tick();
    sel_on();
    rd(4'd4, ed, {t, " day"});
    rd(4'd5, emo, {t, " month"});
    sel_off();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    sel_on();
    rd(4'd0, 8'h00, "R3 reset sec");
    rd(4'd1, 8'h00, "R3 reset min");
    rd(4'd2, 8'h12, "R3 reset hour");
    rd(4'd3, 8'h00, "R3 reset wday");
    rd(4'd4, 8'h01, "R3 reset day");
    rd(4'd5, 8'h01, "R3 reset month");
    rd(4'd6, 8'h00, "R3 reset year");
    rd(4'd14, 8'h00, "R3 reset ctl1");
    rd(4'd15, 8'h10, "R3 reset ctl2");
    rd(4'd9, 8'h00, "R1 unused addr");

    // Field masks and unused addresses
    wr(4'd0, 8'hFF);
    rd(4'd0, 8'h7F, "R1 sec bit7 reads 0");
    wr(4'd2, 8'hFF);
    rd(4'd2, 8'h3F, "R2 hour mask");
    wr(4'd5, 8'hFF);
    rd(4'd5, 8'h9F, "R2 month mask");
    wr(4'd3, 8'hFF);
    rd(4'd3, 8'h07, "R2 wday mask");
    wr(4'd9, 8'h55);
    rd(4'd9, 8'h00, "R2 unused write ignored");

    // Control-2 flags
    wr(4'd15, 8'h5F);
    rd(4'd15, 8'h1F, "R11 write 1 keeps osc flag");
    wr(4'd15, 8'h0F);
    rd(4'd15, 8'h0F, "R11 write 0 clears osc flag");
    sel_off();
    @(negedge clk) vlow_in = 1'b1;
    @(negedge clk) vlow_in = 1'b0;
    sel_on();
    rd(4'd15, 8'h4F, "R11 low voltage sets flag");
    wr(4'd15, 8'h4F);
    rd(4'd15, 8'h4F, "R11 write 1 keeps vlow flag");
    wr(4'd15, 8'h00);
    rd(4'd15, 8'h00, "R11 write 0 clears all");
    sel_off();

    // Seconds and minute carry
    set_time(8'h20, 8'h10, 8'h14, 8'h59, 8'h02, 8'h10, 8'h03, 8'h24);
    pulse_tick();
    sel_on();
    rd(4'd14, 8'h20, "R11 ctl1 mode bit");
    rd(4'd0, 8'h00, "R4 sec wrap");
    rd(4'd1, 8'h15, "R4 minute carry");
    rd(4'd2, 8'h10, "R4 hour unchanged");
    sel_off();

    // Full wrap into a new century
    set_time(8'h20, 8'h23, 8'h59, 8'h58, 8'h06, 8'h31, 8'h12, 8'h99);
    pulse_tick();
    sel_on();
    rd(4'd0, 8'h59, "R4 sec count");
    sel_off();
    pulse_tick();
    sel_on();
    rd(4'd0, 8'h00, "R4 sec wrap full");
    rd(4'd1, 8'h00, "R4 min wrap full");
    rd(4'd2, 8'h00, "R5 24h hour wrap");
    rd(4'd3, 8'h00, "R7 weekday wrap");
    rd(4'd4, 8'h01, "R8 day wrap dec");
    rd(4'd5, 8'h81, "R9 century set");
    rd(4'd6, 8'h00, "R9 year wrap");
    sel_off();

    // 12-hour crossings
    set_time(8'h00, 8'h11, 8'h59, 8'h59, 8'h01, 8'h10, 8'h03, 8'h24);
    pulse_tick();
    sel_on();
    rd(4'd2, 8'h32, "R6 AM11 to PM12");
    rd(4'd4, 8'h10, "R6 noon keeps day");
    sel_off();
    set_time(8'h00, 8'h32, 8'h59, 8'h59, 8'h01, 8'h10, 8'h03, 8'h24);
    pulse_tick();
    sel_on();
    rd(4'd2, 8'h21, "R6 PM12 to PM1");
    sel_off();
    set_time(8'h00, 8'h12, 8'h59, 8'h59, 8'h01, 8'h10, 8'h03, 8'h24);
    pulse_tick();
    sel_on();
    rd(4'd2, 8'h01, "R6 AM12 to AM1");
    sel_off();
    set_time(8'h00, 8'h31, 8'h59, 8'h59, 8'h02, 8'h05, 8'h03, 8'h24);
    pulse_tick();
    sel_on();
    rd(4'd2, 8'h12, "R6 PM11 to midnight");
    rd(4'd4, 8'h06, "R6 midnight day carry");
    rd(4'd3, 8'h03, "R7 weekday step");
    sel_off();

    // Month lengths
    month_end(8'h30, 8'h04, 8'h23, 8'h01, 8'h05, "R8 april 30");
    month_end(8'h30, 8'h05, 8'h23, 8'h31, 8'h05, "R8 may 30");
    month_end(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R8 feb 28 common");
    month_end(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R8 feb 28 leap");
    month_end(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R8 feb 29 leap");
    month_end(8'h28, 8'h82, 8'h00, 8'h29, 8'h82, "R8 feb year 00 leap");
    month_end(8'h30, 8'h11, 8'h23, 8'h01, 8'h12, "R8 nov 30");
    month_end(8'h31, 8'h92, 8'h99, 8'h01, 8'h01, "R9 century toggles off");

    // Ticks held during a session
    set_time(8'h20, 8'h10, 8'h00, 8'h00, 8'h01, 8'h10, 8'h03, 8'h24);
    sel_on();
    pulse_tick();
    @(negedge clk);
    pulse_tick();
    rd(4'd0, 8'h00, "R12 frozen in session");
    sel_off();
    sel_on();
    rd(4'd0, 8'h01, "R10 held ticks apply once");
    rd(4'd1, 8'h00, "R10 minute untouched");
    sel_off();
    pulse_tick();
    sel_on();
    rd(4'd0, 8'h02, "R10 next tick normal");
    sel_off();

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL pending reads act=%0d exp=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule